// File: doc/BRIEF.md
# Phase-Staggered Block Dispatcher for Serial Cipher Cores

This block spreads a stream of 64-bit data blocks over a row of identical bit-serial cipher cores and gathers their results back into a single stream in arrival order. Each core can take one block every 16 cycles and returns its result after a fixed pipeline delay. A 16-position one-hot phase ring gives every core its own slot. Core k owns phase k, so neighbouring cores are one cycle apart, and with 16 cores a block can enter on every cycle.

A block offered in a phase that belongs to a core is loaded into that core. The matching result is picked up again after the core delay. The output side does not store which core holds which block. It works out the core from the current phase, turned back by the core latency. A small delay line carries only the one-bit "a block was taken" marker. When fewer than 16 cores are fitted, a block offered in a phase without a core is dropped and flagged.

Top module: `cipher_core_fanout`

## Requirements
- R1: The phase index is 0 in the first cycle after reset and then advances by one per cycle, wrapping from 15 to 0. Core k (bit k of `core_load`) owns phase k.
- R2: When `in_valid` is high in phase k with k < NUM_CORES, `core_load[k]` is high in the next cycle and only in that cycle. From that cycle on, `core_data[64k+63:64k]` holds the block until core k is loaded again.
- R3: At most one bit of `core_load` is high in any cycle. Each core is loaded at most once in any 16 consecutive cycles.
- R4: A core must drive its result on `core_res[64k+63:64k]` exactly CORE_LAT cycles after the cycle in which its `core_load` bit was high. `out_valid` and `out_block` then show that result CORE_LAT+2 cycles after the cycle in which the block was offered.
- R5: Output blocks leave in the same order as accepted input blocks. Each one is the result of the core that took that block. No output appears without an accepted input.
- R6: With NUM_CORES = 16, a block offered on every cycle is accepted on every cycle, and `phase_err` never rises.
- R7: When `in_valid` is high in a phase k with k >= NUM_CORES, `phase_err` is high in the next cycle for one cycle, and no core is loaded and no output is produced for that block. `in_valid` low in such a phase leaves `phase_err` low.
- R8: During and right after reset, `core_load`, `out_valid` and `phase_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A block is offered this cycle |
| in_block | input | 64 | Offered block |
| core_load | output | NUM_CORES | One-cycle load strobe per core |
| core_data | output | NUM_CORES*64 | Block held for each core, core k at bits 64k+63:64k |
| core_res | input | NUM_CORES*64 | Result from each core, same slicing |
| out_valid | output | 1 | Merged result valid |
| out_block | output | 64 | Merged result block |
| phase_err | output | 1 | Block offered in a phase with no core |

## Verification
Two functions can fall in the same cycle. One is the acceptance of a new block, which produces a load strobe or an error pulse. The other is the merge of a result from a block accepted CORE_LAT+2 cycles earlier. The bench provokes this on a 4-core instance by offering a block in every phase for two full turns of the ring, and on a 16-core instance by offering a block on every cycle, so that loads, error pulses and merged outputs overlap. Each cycle is judged on its own: the load or error strobe must match the phase offered one cycle before. A scoreboard then checks every merged output for data, order and exact arrival cycle, using fixed-latency stand-in cores that apply a core-specific transform.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
  localparam int PHASES = 16;
  localparam int PH_W   = $clog2(PHASES);
  typedef logic [PHASES-1:0] phase_t;

  // rotate a one-hot phase vector back by n positions
  function automatic phase_t rot_back(phase_t v, int unsigned n);
    phase_t r;
    for (int i = 0; i < PHASES; i++) r[i] = v[(i + n) % PHASES];
    return r;
  endfunction
endpackage

// File: rtl/rrd_phase_ring.sv
module rrd_phase_ring
  import rrd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t ring
);
  always_ff @(posedge clk) begin
    if (rst) ring <= phase_t'(1);
    else     ring <= {ring[PHASES-2:0], ring[PHASES-1]};
  end

  // R1: exactly one phase active at all times after reset
  p_ring_onehot_r1: assert property (@(posedge clk) disable iff (rst) $onehot(ring));
endmodule

// File: rtl/rrd_dispatch.sv
module rrd_dispatch
  import rrd_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int BLK_W     = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [BLK_W-1:0]           in_block,
  input  phase_t                     ring,
  output logic [NUM_CORES-1:0]       core_load,
  output logic [NUM_CORES*BLK_W-1:0] core_data,
  output logic                       phase_err
);
  for (genvar k = 0; k < NUM_CORES; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) core_load[k] <= 1'b0;
      else     core_load[k] <= in_valid & ring[k];
    end
    always_ff @(posedge clk) begin
      if (in_valid & ring[k]) core_data[k*BLK_W +: BLK_W] <= in_block;
    end

    // R3: a core is never loaded on two cycles in a row
    p_load_gap_r3: assert property (@(posedge clk) disable iff (rst)
      core_load[k] |=> !core_load[k]);
  end

  if (NUM_CORES < PHASES) begin : g_partial
    always_ff @(posedge clk) begin
      if (rst) phase_err <= 1'b0;
      else     phase_err <= in_valid & (|ring[PHASES-1:NUM_CORES]);
    end
  end else begin : g_full
    always_ff @(posedge clk) begin
      if (rst) phase_err <= 1'b0;
      else     phase_err <= 1'b0;
    end
  end

  // R3: at most one core takes a block per cycle
  p_load_onehot0_r3: assert property (@(posedge clk) disable iff (rst) $onehot0(core_load));
  // R7: a flagged block loads no core
  p_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
    phase_err |-> (core_load == '0));
endmodule

// File: rtl/rrd_valid_delay.sv
module rrd_valid_delay #(
  parameter int DEPTH = 922
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          mem [DEPTH];
  logic [PW-1:0] ptr;
  logic          rd_raw;
  logic          warm;
  logic          rd_ok;

  // read-before-write on one address: block RAM friendly
  always_ff @(posedge clk) begin
    mem[ptr] <= din;
    rd_raw   <= mem[ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      warm  <= 1'b0;
      rd_ok <= 1'b0;
    end else begin
      ptr   <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      if (ptr == PW'(DEPTH - 1)) warm <= 1'b1;
      rd_ok <= warm;
    end
  end

  assign dout = rd_raw & rd_ok;
endmodule

// File: rtl/rrd_merge.sv
module rrd_merge
  import rrd_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int BLK_W     = 64,
  parameter int CORE_LAT  = 923
) (
  input  logic                       clk,
  input  logic                       rst,
  input  phase_t                     ring,
  input  logic                       take,
  input  logic [NUM_CORES*BLK_W-1:0] core_res,
  output logic                       out_valid,
  output logic [BLK_W-1:0]           out_block
);
  localparam int unsigned BACK = (CORE_LAT + 1) % PHASES;

  phase_t           sel;
  logic [BLK_W-1:0] pick;

  assign sel = rot_back(ring, BACK);

  always_comb begin
    pick = '0;
    for (int k = 0; k < NUM_CORES; k++)
      if (sel[k]) pick = pick | core_res[k*BLK_W +: BLK_W];
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= take;
  end
  always_ff @(posedge clk) begin
    if (take) out_block <= pick;
  end

  // R5: a returning block always lands in a phase owned by a core
  p_take_owned_r5: assert property (@(posedge clk) disable iff (rst)
    take |-> (|sel[NUM_CORES-1:0]));
endmodule

// File: rtl/cipher_core_fanout.sv
module cipher_core_fanout
  import rrd_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int BLK_W     = 64,
  parameter int CORE_LAT  = 923
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [BLK_W-1:0]           in_block,
  output logic [NUM_CORES-1:0]       core_load,
  output logic [NUM_CORES*BLK_W-1:0] core_data,
  input  logic [NUM_CORES*BLK_W-1:0] core_res,
  output logic                       out_valid,
  output logic [BLK_W-1:0]           out_block,
  output logic                       phase_err
);
  localparam int DLY_DEPTH = CORE_LAT - 1;

  phase_t ring;
  logic   accepted;
  logic   take;

  rrd_phase_ring u_ring (
    .clk  (clk),
    .rst  (rst),
    .ring (ring)
  );

  rrd_dispatch #(.NUM_CORES(NUM_CORES), .BLK_W(BLK_W)) u_disp (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_block  (in_block),
    .ring      (ring),
    .core_load (core_load),
    .core_data (core_data),
    .phase_err (phase_err)
  );

  assign accepted = |core_load;

  rrd_valid_delay #(.DEPTH(DLY_DEPTH)) u_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (accepted),
    .dout (take)
  );

  rrd_merge #(.NUM_CORES(NUM_CORES), .BLK_W(BLK_W), .CORE_LAT(CORE_LAT)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .ring      (ring),
    .take      (take),
    .core_res  (core_res),
    .out_valid (out_valid),
    .out_block (out_block)
  );

  // R8: nothing is strobed in the cycle after reset is released
  p_quiet_after_reset_r8: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !phase_err && core_load == '0));
endmodule

// File: tb/cipher_core_fanout_tb.sv
module lat_stub #(
  parameter int LAT = 20,
  parameter int TAG = 0
) (
  input  logic        clk,
  input  logic [63:0] din,
  output logic [63:0] dout
);
  logic [63:0] pipe [LAT];
  function automatic logic [63:0] xf(logic [63:0] x, int k);
    return {x[47:0], x[63:48]} ^ {4{4'(k), 4'(k + 5), 8'h3C}};
  endfunction
  always_ff @(posedge clk) begin
    pipe[0] <= xf(din, TAG);
    for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
  end
  assign dout = pipe[LAT-1];
endmodule

module cipher_core_fanout_tb;
  localparam int LAT = 20;
  localparam int NA  = 4;
  localparam int NB  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  logic [3:0] ph;
  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) ph <= '0; else ph <= ph + 4'd1;
  end

  function automatic logic [63:0] xf(logic [63:0] x, int k);
    return {x[47:0], x[63:48]} ^ {4{4'(k), 4'(k + 5), 8'h3C}};
  endfunction

  // DUT A: 4 cores
  logic a_valid = 1'b0;
  logic [63:0] a_block = '0;
  logic [NA-1:0] a_load;
  logic [NA*64-1:0] a_data, a_res;
  logic a_ovalid, a_err;
  logic [63:0] a_oblock;

  cipher_core_fanout #(.NUM_CORES(NA), .BLK_W(64), .CORE_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .in_valid(a_valid), .in_block(a_block),
    .core_load(a_load), .core_data(a_data), .core_res(a_res),
    .out_valid(a_ovalid), .out_block(a_oblock), .phase_err(a_err));

  for (genvar k = 0; k < NA; k++) begin : g_sa
    lat_stub #(.LAT(LAT), .TAG(k)) u_s (.clk(clk), .din(a_data[k*64 +: 64]), .dout(a_res[k*64 +: 64]));
  end

  // DUT B: 16 cores
  logic b_valid = 1'b0;
  logic [63:0] b_block = '0;
  logic [NB-1:0] b_load;
  logic [NB*64-1:0] b_data, b_res;
  logic b_ovalid, b_err;
  logic [63:0] b_oblock;

  cipher_core_fanout #(.NUM_CORES(NB), .BLK_W(64), .CORE_LAT(LAT)) u_dut_full (
    .clk(clk), .rst(rst), .in_valid(b_valid), .in_block(b_block),
    .core_load(b_load), .core_data(b_data), .core_res(b_res),
    .out_valid(b_ovalid), .out_block(b_oblock), .phase_err(b_err));

  for (genvar k = 0; k < NB; k++) begin : g_sb
    lat_stub #(.LAT(LAT), .TAG(k)) u_s (.clk(clk), .din(b_data[k*64 +: 64]), .dout(b_res[k*64 +: 64]));
  end

  logic [63:0] qa_d[$];
  int          qa_t[$];
  logic [63:0] qb_d[$];
  int          qb_t[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboards: data, order and arrival cycle of merged outputs
  always @(negedge clk) begin
    if (!rst && a_ovalid) begin
      if (qa_d.size() == 0) check(1'b0, "R5 unexpected output A", a_oblock, 64'h0);
      else begin
        check(a_oblock == qa_d[0], "R5 data/order A", a_oblock, qa_d[0]);
        check(cyc == qa_t[0], "R4 latency A", 64'(cyc), 64'(qa_t[0]));
        void'(qa_d.pop_front()); void'(qa_t.pop_front());
      end
    end
    if (!rst && b_ovalid) begin
      if (qb_d.size() == 0) check(1'b0, "R5 unexpected output B", b_oblock, 64'h0);
      else begin
        check(b_oblock == qb_d[0], "R5 data/order B", b_oblock, qb_d[0]);
        check(cyc == qb_t[0], "R4 latency B", 64'(cyc), 64'(qb_t[0]));
        void'(qb_d.pop_front()); void'(qb_t.pop_front());
      end
    end
  end

  task automatic wait_phase(input int p);
    while (ph != 4'(p)) @(negedge clk);
  endtask

  // drive one cycle on A (called at a negedge), check strobes at the next negedge
  task automatic step_a(input logic v, input logic [63:0] d);
    int p;
    logic [NA-1:0] exp_load;
    p = int'(ph);
    a_valid = v; a_block = d;
    exp_load = (v && p < NA) ? NA'(1 << p) : '0;
    if (v && p < NA) begin qa_d.push_back(xf(d, p)); qa_t.push_back(cyc + LAT + 2); end
    @(negedge clk);
    a_valid = 1'b0;
    check(a_load == exp_load, "R1/R2 load A", 64'(a_load), 64'(exp_load));
    check(a_err == (v && p >= NA), "R7 phase_err A", 64'(a_err), 64'(v && p >= NA));
    if (v && p < NA) check(a_data[p*64 +: 64] == d, "R2 core_data A", a_data[p*64 +: 64], d);
  endtask

  task automatic t_reset();
    check(a_load == '0 && b_load == '0, "R8 load at reset", 64'({a_load, b_load}), 64'h0);
    check(!a_ovalid && !b_ovalid, "R8 out_valid at reset", 64'({a_ovalid, b_ovalid}), 64'h0);
    check(!a_err && !b_err, "R8 phase_err at reset", 64'({a_err, b_err}), 64'h0);
  endtask

  task automatic t_single();
    logic [63:0] held;
    wait_phase(0);
    step_a(1'b1, 64'h0123_4567_89AB_CDEF);
    // R2: data held while other cores are loaded
    held = a_data[63:0];
    for (int i = 0; i < 5; i++) step_a(1'b0, 64'hDEAD_0000_0000_0000);
    check(a_data[63:0] == held, "R2 core_data held", a_data[63:0], held);
  endtask

  task automatic t_walk();
    int loads [NA];
    for (int k = 0; k < NA; k++) loads[k] = 0;
    wait_phase(0);
    for (int i = 0; i < 32; i++) begin
      step_a(1'b1, {32'hA11C_0000 + 32'(i), 32'(cyc)});
      for (int k = 0; k < NA; k++) if (a_load[k]) loads[k]++;
      check($countones(a_load) <= 1, "R3 one load per cycle", 64'(a_load), 64'h0);
    end
    for (int k = 0; k < NA; k++)
      check(loads[k] == 2, "R3 two loads per core in 32 cycles", 64'(loads[k]), 64'd2);
  endtask

  task automatic t_idle_err();
    wait_phase(9);
    step_a(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    check(!a_err, "R7 no flag without valid", 64'(a_err), 64'h0);
    wait_phase(12);
    step_a(1'b1, 64'h5555_AAAA_5555_AAAA);
  endtask

  task automatic t_full();
    int p;
    logic [63:0] d;
    wait_phase(5);
    for (int i = 0; i < 40; i++) begin
      p = int'(ph);
      d = {32'hB00B_0000 + 32'(i), 32'(cyc * 7)};
      b_valid = 1'b1; b_block = d;
      qb_d.push_back(xf(d, p)); qb_t.push_back(cyc + LAT + 2);
      @(negedge clk);
      check(b_load == NB'(1 << p), "R6 accept every cycle", 64'(b_load), 64'(1 << p));
      check(!b_err, "R6 no phase_err", 64'(b_err), 64'h0);
    end
    b_valid = 1'b0;
  endtask

  task automatic t_drain();
    repeat (LAT + 6) @(negedge clk);
    check(qa_d.size() == 0, "R5 all A outputs seen", 64'(qa_d.size()), 64'h0);
    check(qb_d.size() == 0, "R5 all B outputs seen", 64'(qb_d.size()), 64'h0);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_walk();
    t_idle_err();
    t_full();
    t_drain();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule